// File: doc/BRIEF.md
# Packed Character Access Unit

This block reads and writes 6-bit characters that are packed three to an 18-bit memory word. A character pointer, held inside the block, selects the character: it is a word address together with a slot number from 0 to 2. A load fetches the addressed word and places the selected character in the accumulator result. A deposit fetches the word, replaces the selected character with the low six bits of the accumulator operand, and writes the word back. The other two characters of the word are left as they were.

Each command has a variant that advances the pointer once the access finishes. The slot steps 0, 1, 2, then back to 0, and the word address moves forward only when the slot wraps. With ring mode set, address advance is confined to the aligned block of eight words that holds the pointer. Without it, the address counts through the whole address space and wraps at the end.

Commands enter through a valid/ready handshake. `cmd_ready` is high only while the block is idle, so a requester holds `cmd_valid` until it sees ready, and the command is taken on the edge where both are high. No back-pressure applies to the results: `done` is a single-cycle pulse that cannot be stalled. The memory port drives a synchronous single-port RAM whose read data comes back one cycle after the request.

Top module: `pchar_unit`

## Requirements
- R1: A load (cmd_op 6'o12 or 6'o13) sets acc_out to the selected character in acc_out[5:0] with acc_out[17:6] cleared. Slot 0 is word bits [17:12], slot 1 is bits [11:6] and slot 2 is bits [5:0].
- R2: A deposit (cmd_op 6'o14 or 6'o15) writes back the fetched word with acc_in[5:0] in the selected slot and the other two slots unchanged. acc_out then equals the acc_in value taken with the command.
- R3: Codes 6'o12 (load) and 6'o14 (deposit) leave the pointer unchanged. Codes 6'o13 and 6'o15 do the same access and then advance the pointer. Any other cmd_op is accepted and dropped: it makes no memory access, gives no done, and leaves the pointer and acc_out as they were.
- R4: Advancing moves slot 0 to 1 and slot 1 to 2 with the address unchanged. Slot 2 goes to 0 and the address advances.
- R5: When ring_mode is 1 at command acceptance, address advance increments only ptr_addr[2:0] modulo 8 and keeps the upper address bits.
- R6: When ring_mode is 0, address advance is ptr_addr+1 modulo 2^ADDR_W.
- R7: Slot value 3 is accessed as slot 0 and advances as slot 0 would. pos_err is high for exactly the done cycle of that command.
- R8: mem_en is high for one cycle, the cycle right after the accepting edge, with mem_we low. A load raises done two edges after the accepting edge. A deposit raises mem_en and mem_we together on the cycle after the read data arrives, and raises done three edges after acceptance.
- R9: ptr_load while cmd_ready is high copies ptr_addr_in and ptr_pos_in into the pointer on that edge, and a command taken on the same edge uses the new pointer. ptr_load while busy is ignored.
- R10: done lasts one cycle. The updated pointer and acc_out are visible in the done cycle, and cmd_ready stays low from acceptance through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 6 | Command code |
| ring_mode | input | 1 | Confine address advance to an 8-word block |
| ptr_load | input | 1 | Write the pointer |
| ptr_addr_in | input | ADDR_W | New pointer word address |
| ptr_pos_in | input | 2 | New pointer slot |
| ptr_addr | output | ADDR_W | Pointer word address |
| ptr_pos | output | 2 | Pointer slot |
| acc_in | input | 18 | Accumulator operand |
| acc_out | output | 18 | Accumulator result |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 18 | Memory write data |
| mem_rdata | input | 18 | Memory read data, one cycle after request |
| done | output | 1 | Command finished pulse |
| pos_err | output | 1 | Illegal slot seen, with done |

## Verification
Counting the accepting edge as edge 0, the read request is due at the sample just after edge 0 and the write at the sample after edge 2. done is due after edge 2 for a load and after edge 3 for a deposit. The bench drives every command at a falling edge and samples 1 ns after each rising edge from edge 0 on. It records the index of the sample where done appears and counts the cycles with mem_en and mem_we high, then compares these with the per-opcode values above. Pointer, accumulator, error flag and the bench's own memory model are all compared in that done sample.

// File: rtl/pchar_pkg.sv
package pchar_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_CAP  = 3'd2,
    ST_WR   = 3'd3,
    ST_FIN  = 3'd4
  } pc_state_e;

  localparam logic [5:0] OP_LOAD     = 6'o12;
  localparam logic [5:0] OP_LOAD_INC = 6'o13;
  localparam logic [5:0] OP_DEP      = 6'o14;
  localparam logic [5:0] OP_DEP_INC  = 6'o15;

  typedef struct packed {
    logic legal;
    logic is_dep;
    logic inc;
  } pc_cmd_t;

  function automatic pc_cmd_t decode_op(input logic [5:0] op);
    pc_cmd_t c;
    c.legal  = (op == OP_LOAD) || (op == OP_LOAD_INC) || (op == OP_DEP) || (op == OP_DEP_INC);
    c.is_dep = (op == OP_DEP) || (op == OP_DEP_INC);
    c.inc    = (op == OP_LOAD_INC) || (op == OP_DEP_INC);
    return c;
  endfunction
endpackage

// File: rtl/pchar_lane.sv
module pchar_lane #(
  parameter int CHAR_W = 6,
  parameter int SLOTS  = 3,
  localparam int WORD_W = CHAR_W * SLOTS,
  localparam int SLOT_W = $clog2(SLOTS + 1)
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [SLOT_W-1:0] slot,
  input  logic [CHAR_W-1:0] ch_in,
  output logic [CHAR_W-1:0] ch_out,
  output logic [WORD_W-1:0] merged
);
  logic [CHAR_W-1:0] field [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int HI = WORD_W - 1 - s * CHAR_W;
    assign field[s] = word_in[HI -: CHAR_W];
    assign merged[HI -: CHAR_W] = (slot == SLOT_W'(s)) ? ch_in : word_in[HI -: CHAR_W];
  end

  always_comb begin
    ch_out = '0;
    for (int s = 0; s < SLOTS; s++)
      if (slot == SLOT_W'(s)) ch_out = field[s];
  end
endmodule

// File: rtl/pchar_ptr.sv
module pchar_ptr #(
  parameter int ADDR_W = 12,
  parameter int SLOTS  = 3,
  parameter int RING_W = 3,
  localparam int SLOT_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [SLOT_W-1:0] load_pos,
  input  logic              step_en,
  input  logic              ring,
  output logic [ADDR_W-1:0] addr,
  output logic [SLOT_W-1:0] pos,
  output logic [SLOT_W-1:0] eff_pos,
  output logic              pos_bad
);
  logic [ADDR_W-1:0] addr_adv;

  assign pos_bad = (pos >= SLOT_W'(SLOTS));
  assign eff_pos = pos_bad ? '0 : pos;

  if (ADDR_W > RING_W) begin : g_ring
    logic [RING_W-1:0] low_inc;
    assign low_inc  = addr[RING_W-1:0] + 1'b1;
    assign addr_adv = ring ? {addr[ADDR_W-1:RING_W], low_inc} : addr + 1'b1;
  end else begin : g_flat
    logic unused_ring;
    assign unused_ring = ring;
    assign addr_adv    = addr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      pos  <= '0;
    end else if (load_en) begin
      addr <= load_addr;
      pos  <= load_pos;
    end else if (step_en) begin
      if (eff_pos == SLOT_W'(SLOTS - 1)) begin
        pos  <= '0;
        addr <= addr_adv;
      end else begin
        pos <= eff_pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pchar_ctrl.sv
module pchar_ctrl
  import pchar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [5:0] cmd_op,
  input  logic       ring_in,
  output logic       cmd_ready,
  output logic       take,
  output logic       st_rd,
  output logic       st_cap,
  output logic       st_wr,
  output logic       st_fin,
  output logic       fin_next,
  output logic       dep_q,
  output logic       inc_q,
  output logic       ring_q
);
  pc_state_e state, state_n;
  pc_cmd_t   dec;

  assign dec       = decode_op(cmd_op);
  assign cmd_ready = (state == ST_IDLE);
  assign take      = cmd_ready && cmd_valid && dec.legal;
  assign st_rd     = (state == ST_RD);
  assign st_cap    = (state == ST_CAP);
  assign st_wr     = (state == ST_WR);
  assign st_fin    = (state == ST_FIN);
  assign fin_next  = (state_n == ST_FIN);

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE: if (take) state_n = ST_RD;
      ST_RD:   state_n = ST_CAP;
      ST_CAP:  state_n = dep_q ? ST_WR : ST_FIN;
      ST_WR:   state_n = ST_FIN;
      ST_FIN:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      dep_q  <= 1'b0;
      inc_q  <= 1'b0;
      ring_q <= 1'b0;
    end else begin
      state <= state_n;
      if (take) begin
        dep_q  <= dec.is_dep;
        inc_q  <= dec.inc;
        ring_q <= ring_in;
      end
    end
  end
endmodule

// File: rtl/pchar_unit.sv
module pchar_unit #(
  parameter int ADDR_W = 12,
  parameter int CHAR_W = 6,
  parameter int SLOTS  = 3,
  parameter int RING_W = 3,
  localparam int WORD_W = CHAR_W * SLOTS,
  localparam int SLOT_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [5:0]        cmd_op,
  input  logic              ring_mode,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_addr_in,
  input  logic [SLOT_W-1:0] ptr_pos_in,
  output logic [ADDR_W-1:0] ptr_addr,
  output logic [SLOT_W-1:0] ptr_pos,
  input  logic [WORD_W-1:0] acc_in,
  output logic [WORD_W-1:0] acc_out,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic              pos_err
);
  logic              take, st_rd, st_cap, st_wr, st_fin, fin_next;
  logic              dep_q, inc_q, ring_q;
  logic [SLOT_W-1:0] eff_pos;
  logic              pos_bad;
  logic [WORD_W-1:0] word_q, acc_q, merged;
  logic [CHAR_W-1:0] rd_char;
  logic              err_q;

  pchar_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .ring_in(ring_mode), .cmd_ready(cmd_ready), .take(take),
    .st_rd(st_rd), .st_cap(st_cap), .st_wr(st_wr), .st_fin(st_fin),
    .fin_next(fin_next), .dep_q(dep_q), .inc_q(inc_q), .ring_q(ring_q)
  );

  pchar_ptr #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .RING_W(RING_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load_en(ptr_load && cmd_ready),
    .load_addr(ptr_addr_in), .load_pos(ptr_pos_in),
    .step_en(fin_next && inc_q), .ring(ring_q),
    .addr(ptr_addr), .pos(ptr_pos), .eff_pos(eff_pos), .pos_bad(pos_bad)
  );

  // Extract from live read data (load); merge into captured word (deposit).
  pchar_lane #(.CHAR_W(CHAR_W), .SLOTS(SLOTS)) u_rd_lane (
    .word_in(mem_rdata), .slot(eff_pos), .ch_in(acc_q[CHAR_W-1:0]),
    .ch_out(rd_char), .merged()
  );

  pchar_lane #(.CHAR_W(CHAR_W), .SLOTS(SLOTS)) u_wr_lane (
    .word_in(word_q), .slot(eff_pos), .ch_in(acc_q[CHAR_W-1:0]),
    .ch_out(), .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      acc_q   <= '0;
      acc_out <= '0;
      err_q   <= 1'b0;
    end else begin
      if (take) acc_q <= acc_in;
      if (st_cap) word_q <= mem_rdata;
      if (fin_next) acc_out <= dep_q ? acc_q : {{(WORD_W-CHAR_W){1'b0}}, rd_char};
      err_q <= fin_next && pos_bad;
    end
  end

  assign mem_en    = st_rd || st_wr;
  assign mem_we    = st_wr;
  assign mem_addr  = ptr_addr;
  assign mem_wdata = merged;
  assign done      = st_fin;
  assign pos_err   = err_q;
endmodule

// File: rtl/pchar_unit_chk.sv
module pchar_unit_chk #(
  parameter int ADDR_W = 12,
  parameter int RING_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              ring_mode,
  input logic [ADDR_W-1:0] ptr_addr,
  input logic              mem_en,
  input logic              mem_we,
  input logic              done,
  input logic              pos_err
);
  logic acc_d, ring_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_d  <= 1'b0;
      ring_c <= 1'b0;
    end else begin
      acc_d <= cmd_valid && cmd_ready;
      if (cmd_valid && cmd_ready) ring_c <= ring_mode;
    end
  end

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r10_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n) done |-> !cmd_ready);
  a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n) pos_err |-> done);
  a_r8_write_needs_en: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> mem_en);
  a_r8_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_en && !mem_we, 2));

  if (ADDR_W > RING_W) begin : g_ring_chk
    logic [ADDR_W-RING_W-1:0] up_c;
    always_ff @(posedge clk) begin
      if (!rst_n) up_c <= '0;
      else if (acc_d) up_c <= ptr_addr[ADDR_W-1:RING_W];
    end
    a_r5_ring_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ring_c) |-> (ptr_addr[ADDR_W-1:RING_W] == up_c));
  end
endmodule

bind pchar_unit pchar_unit_chk #(.ADDR_W(ADDR_W), .RING_W(RING_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .ring_mode(ring_mode), .ptr_addr(ptr_addr), .mem_en(mem_en), .mem_we(mem_we),
  .done(done), .pos_err(pos_err)
);

// File: tb/test_pchar_unit.sv
module test_pchar_unit;
  localparam int AW = 4;
  localparam int NW = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, ring_mode = 0, ptr_load = 0;
  logic [5:0] cmd_op = '0;
  logic [AW-1:0] ptr_addr_in = '0;
  logic [1:0] ptr_pos_in = '0;
  logic [17:0] acc_in = '0;
  logic cmd_ready, mem_en, mem_we, done, pos_err;
  logic [AW-1:0] ptr_addr, mem_addr;
  logic [1:0] ptr_pos;
  logic [17:0] acc_out, mem_wdata, mem_rdata;

  logic [17:0] mem [NW];
  logic [17:0] ref_mem [NW];
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  pchar_unit #(.ADDR_W(AW)) i_pchar_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .ring_mode(ring_mode), .ptr_load(ptr_load),
    .ptr_addr_in(ptr_addr_in), .ptr_pos_in(ptr_pos_in), .ptr_addr(ptr_addr),
    .ptr_pos(ptr_pos), .acc_in(acc_in), .acc_out(acc_out), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .pos_err(pos_err)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // One command with pointer loaded on the same edge; checks every result.
  task automatic run_op(input logic [5:0] op, input int a, input int p, input bit rg, input logic [17:0] acc);
    bit dep, inc;
    int ep, sh, done_at, en_n, we_n, exp_a, exp_p;
    logic [17:0] exp_acc, exp_w;
    dep = (op == 6'o14) || (op == 6'o15);
    inc = (op == 6'o13) || (op == 6'o15);
    ep = (p == 3) ? 0 : p;
    sh = 6 * (2 - ep);
    if (dep) begin
      exp_w = (ref_mem[a] & ~(18'h3f << sh)) | ((acc & 18'h3f) << sh);
      exp_acc = acc;
    end else begin
      exp_w = ref_mem[a];
      exp_acc = (ref_mem[a] >> sh) & 18'h3f;
    end
    exp_a = a; exp_p = p;
    if (inc) begin
      if (ep == 2) begin
        exp_p = 0;
        exp_a = rg ? ((a & ~7) | ((a + 1) & 7)) : ((a + 1) % NW);
      end else exp_p = ep + 1;
    end
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; ring_mode = rg; acc_in = acc;
    ptr_load = 1; ptr_addr_in = AW'(a); ptr_pos_in = 2'(p);
    @(posedge clk); #1;
    cmd_valid = 0; ptr_load = 0;
    done_at = -1; en_n = 0; we_n = 0;
    for (int n = 0; n < 7; n++) begin
      if (n > 0) begin @(posedge clk); #1; end
      if (mem_en) en_n++;
      if (mem_we) we_n++;
      if (done && done_at < 0) begin
        done_at = n;
        chk(acc_out == exp_acc, dep ? "R2 acc" : "R1 load char", acc_out, exp_acc);
        chk(ptr_addr == AW'(exp_a), rg ? "R5 addr" : "R6/R4 addr", ptr_addr, exp_a);
        chk(ptr_pos == 2'(exp_p), "R4 pos", ptr_pos, exp_p);
        chk(pos_err == (p == 3), "R7 err", pos_err, p == 3);
        chk(mem[a] == exp_w, dep ? "R2 merge" : "R1 word kept", mem[a], exp_w);
      end
      if (done_at >= 0 && n == done_at + 1) chk(!done && cmd_ready, "R10 one-cycle done", done, 0);
    end
    chk(done_at == (dep ? 3 : 2), "R8 done timing", done_at, dep ? 3 : 2);
    chk(en_n == (dep ? 2 : 1) && we_n == (dep ? 1 : 0), "R8 mem cycles", en_n * 16 + we_n, dep ? 33 : 16);
    ref_mem[a] = exp_w;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] ops [4];
    ops[0] = 6'o12; ops[1] = 6'o13; ops[2] = 6'o14; ops[3] = 6'o15;
    for (int i = 0; i < NW; i++) begin
      mem[i] = 18'((i * 40503 + 7919) ^ (i << 11));
      ref_mem[i] = mem[i];
    end
    repeat (3) @(posedge clk);
    #1;
    chk(cmd_ready && !done && !mem_en && ptr_addr == 0 && ptr_pos == 0 && acc_out == 0,
        "R10 reset state", {acc_out, ptr_addr, ptr_pos}, 0);
    @(negedge clk); rst_n = 1;

    // Sweep: every address, slot (incl. 3), opcode and ring setting.
    for (int rg = 0; rg < 2; rg++)
      for (int a = 0; a < NW; a++)
        for (int p = 0; p < 4; p++)
          for (int o = 0; o < 4; o++)
            run_op(ops[o], a, p, rg[0], 18'((a * 977 + p * 311 + o * 53 + rg * 7) * 131));

    // R3: unknown opcode is dropped; pointer load on that edge still applies (R9).
    @(negedge clk);
    cmd_valid = 1; cmd_op = 6'o16; ptr_load = 1; ptr_addr_in = 4'd9; ptr_pos_in = 2'd1; acc_in = 18'h2aaaa;
    begin
      logic [17:0] acc_before;
      bit any;
      acc_before = acc_out;
      @(posedge clk); #1;
      cmd_valid = 0; ptr_load = 0;
      any = 0;
      for (int n = 0; n < 5; n++) begin
        if (done || mem_en || !cmd_ready) any = 1;
        @(posedge clk); #1;
      end
      chk(!any, "R3 unknown op no activity", any, 0);
      chk(acc_out == acc_before, "R3 acc unchanged", acc_out, acc_before);
      chk(ptr_addr == 4'd9 && ptr_pos == 2'd1, "R9 idle pointer load", {ptr_addr, ptr_pos}, {4'd9, 2'd1});
    end

    // R9: pointer load while busy is ignored.
    @(negedge clk);
    cmd_valid = 1; cmd_op = 6'o13; ring_mode = 0; ptr_load = 1; ptr_addr_in = 4'd5; ptr_pos_in = 2'd2;
    @(posedge clk); #1;
    cmd_valid = 0; ptr_addr_in = 4'd12; ptr_pos_in = 2'd0;
    begin
      bit seen;
      seen = 0;
      for (int n = 0; n < 5; n++) begin
        if (done) begin
          seen = 1;
          ptr_load = 0;
          chk(ptr_addr == 4'd6 && ptr_pos == 2'd0, "R9 busy load ignored", {ptr_addr, ptr_pos}, {4'd6, 2'd0});
        end
        @(posedge clk); #1;
      end
      chk(seen, "R10 done seen", seen, 1);
    end
    ptr_load = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule